// File: doc/BRIEF.md
# SPI Panel Configuration Register Target

This block is the configuration register bank of a small TFT panel controller, reached from a host through a four-wire SPI target port. Every access is one 16-clock frame, sent most significant bit first. The first byte is a header: bit 7 picks the direction (1 reads, 0 writes) and bits 6:0 name the register. On a write, the second byte is stored. On a read, the content of the named register is returned on the data-out pin during the second byte.

The SPI pins are sampled by the block's own system clock. That clock must run several times faster than the serial clock. Besides the host-visible storage, the block decodes three registers into fields for downstream display logic:
- the scan and input-format register,
- the supply-sequencing register,
- the signal-polarity register.

It also holds a fixed identification value at address 0. A host can return the whole bank to its defaults by writing one register.

Top module: `panel_cfg_spi`

## Requirements
- R1: A frame is SPI mode 0 (data sampled on rising SCK, changed on falling SCK) with chip select low, MSB first. Header bit 7 = 1 means read and 0 means write, and header bits 6:0 are the address. A write takes effect only after the 16th rising SCK edge of the frame; further edges in the same frame are ignored.
- R2: On a read, the addressed register appears on `spi_miso` MSB first. Bit 7 is valid from the 8th falling SCK edge, and each later bit follows on each falling edge.
- R3: `spi_miso_oe` is 1 only while chip select is low, the header says read and the second byte is in progress. Whenever `spi_miso_oe` is 0, `spi_miso` is 0.
- R4: A frame with fewer than 16 SCK rising edges before chip select rises changes no register.
- R5: Address 0x00 always reads 0x96, and writes to it have no effect.
- R6: Addresses above 0x44 read as 0x00, and writes to them have no effect.
- R7: Defaults are 0x01=0x0F, 0x02=0x2E, 0x03=0x12, 0x04=0x01, 0x06=0x03, 0x07=0x80 and 0x0A=0x09. Every other address from 0x05 to 0x44 defaults to 0x00.
- R8: Writing 0x04 with bit 0 = 0 returns every register, 0x04 included, to its default. Writing 0x04 with bit 0 = 1 stores the value like any other register.
- R9: Bit 7 of register 0x07 always reads 1, whatever value was written.
- R10: The decoded outputs follow the stored registers:
  - Register 0x06: bit 0 gives `cfg_hdir`, bit 1 gives `cfg_vdir`, bits 3:2 give `cfg_video_std` (0 NTSC, 1 PAL, 3 autodetect) and bits 7:4 give `cfg_in_fmt`.
  - Register 0x07: bit 0 gives `cfg_pwr_normal`, bits 5:1 give `cfg_rail_en` and bit 6 gives `cfg_pwr_auto`.
  - Register 0x0A: bits 0 to 6 give `cfg_clk_rise`, `cfg_hs_high`, `cfg_vs_high`, `cfg_de_high`, `cfg_swap_chroma`, `cfg_formula_b` and `cfg_data_rev`, in that order.
- R11: Driving `rst_n` low, at any time, returns all registers to the defaults of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when not driven |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| cfg_hdir | output | 1 | Horizontal scan direction |
| cfg_vdir | output | 1 | Vertical scan direction |
| cfg_video_std | output | 2 | Video standard select |
| cfg_in_fmt | output | 4 | Input format select |
| cfg_pwr_normal | output | 1 | 1 = normal operation, 0 = standby |
| cfg_rail_en | output | 5 | Supply rail enables |
| cfg_pwr_auto | output | 1 | Automatic supply sequencing |
| cfg_clk_rise | output | 1 | Pixel clock edge select |
| cfg_hs_high | output | 1 | Horizontal sync active high |
| cfg_vs_high | output | 1 | Vertical sync active high |
| cfg_de_high | output | 1 | Data-enable active high |
| cfg_swap_chroma | output | 1 | Swapped chroma / colour order |
| cfg_formula_b | output | 1 | Alternate colour conversion formula |
| cfg_data_rev | output | 1 | Reversed data range |

## Verification
The assertions assume three things about the inputs:
- SCK, chip select and MOSI are slow against `clk`, so each SCK level lasts several system cycles after synchronisation.
- MOSI is stable around each rising SCK edge.
- Chip select changes only while SCK is low.

The stimulus keeps to these rules. It holds every SCK phase for eight system cycles and changes MOSI only on the falling side. It toggles chip select at least eight cycles away from any SCK edge. Truncated frames still end with SCK low, so the frame counter is cleared by chip select and never by a stray edge.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;

   localparam int CFG_DW = 8;

   localparam int A_ID    = 'h00;
   localparam int A_SWRST = 'h04;
   localparam int A_ENTRY = 'h06;
   localparam int A_PWR   = 'h07;
   localparam int A_POL   = 'h0A;

   function automatic logic [CFG_DW-1:0] cfg_default(input int a);
      case (a)
         'h01:    return 8'h0F;
         'h02:    return 8'h2E;
         'h03:    return 8'h12;
         A_SWRST: return 8'h01;
         A_ENTRY: return 8'h03;
         A_PWR:   return 8'h80;
         A_POL:   return 8'h09;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/pcfg_spi_front.sv
module pcfg_spi_front #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] rd_data
);

   localparam int FRAME = 2 * DATA_W;
   localparam int CNT_W = $clog2(FRAME + 1);
   localparam logic [CNT_W-1:0] C_HDR  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] C_DAT0 = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] C_LAST = CNT_W'(FRAME - 1);
   localparam logic [CNT_W-1:0] C_END  = CNT_W'(FRAME);

   logic sck_s, cs_s, mosi_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sck_s  = spi_sck;
         assign cs_s   = spi_cs_n;
         assign mosi_s = spi_mosi;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sck_ch, cs_ch, mosi_ch;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_ch  <= '0;
               cs_ch   <= '1;
               mosi_ch <= '0;
            end else begin
               sck_ch  <= SYNC_STAGES'({sck_ch, spi_sck});
               cs_ch   <= SYNC_STAGES'({cs_ch, spi_cs_n});
               mosi_ch <= SYNC_STAGES'({mosi_ch, spi_mosi});
            end
         end
         assign sck_s  = sck_ch[SYNC_STAGES-1];
         assign cs_s   = cs_ch[SYNC_STAGES-1];
         assign mosi_s = mosi_ch[SYNC_STAGES-1];
      end
   endgenerate

   logic              sck_q;
   logic              cs_act, rise, fall;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-2:0] sh;
   logic [DATA_W-1:0] hdr;
   logic [DATA_W-1:0] tx;
   logic              ld;
   logic              hdr_rd;

   assign cs_act   = ~cs_s;
   assign rise     = cs_act & sck_s & ~sck_q;
   assign fall     = cs_act & ~sck_s & sck_q;
   assign hdr_rd   = hdr[DATA_W-1];
   assign acc_addr = hdr[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         cnt     <= '0;
         sh      <= '0;
         hdr     <= '0;
         wr_data <= '0;
         wr_stb  <= 1'b0;
         ld      <= 1'b0;
         tx      <= '0;
      end else begin
         sck_q  <= sck_s;
         wr_stb <= 1'b0;
         ld     <= 1'b0;
         if (!cs_act) begin
            cnt <= '0;
            hdr <= '0;
            tx  <= '0;
         end else begin
            if (rise && cnt != C_END) begin
               sh  <= {sh[DATA_W-3:0], mosi_s};
               cnt <= cnt + 1'b1;
               if (cnt == C_HDR) begin
                  hdr <= {sh, mosi_s};
                  ld  <= 1'b1;
               end
               if (cnt == C_LAST) begin
                  wr_data <= {sh, mosi_s};
                  wr_stb  <= ~hdr_rd;
               end
            end
            if (ld)
               tx <= rd_data;
            else if (fall && cnt > C_DAT0 && cnt != C_END)
               tx <= {tx[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign spi_miso_oe = cs_act & hdr_rd & (cnt >= C_DAT0) & (cnt != C_END);
   assign spi_miso    = spi_miso_oe & tx[DATA_W-1];

   // R1
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   // R1
   wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !hdr_rd);
   // R3
   miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_miso_oe |-> !spi_miso);

endmodule

// File: rtl/pcfg_regbank.sv
module pcfg_regbank
   import panel_cfg_pkg::*;
#(
   parameter int          ADDR_W    = 7,
   parameter int          LAST_ADDR = 'h44,
   parameter logic [7:0]  ID_VALUE  = 8'h96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              wr_stb,
   input  logic [CFG_DW-1:0] wr_data,
   output logic [CFG_DW-1:0] rd_data,
   output logic [CFG_DW-1:0] entry_q,
   output logic [CFG_DW-1:0] pwr_q,
   output logic [CFG_DW-1:0] pol_q
);

   localparam int NREG = LAST_ADDR + 1;
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(LAST_ADDR);
   localparam logic [ADDR_W-1:0] SWRST_A = ADDR_W'(A_SWRST);
   localparam logic [ADDR_W-1:0] PWR_A   = ADDR_W'(A_PWR);

   logic [CFG_DW-1:0] regs [NREG];
   logic              in_range, glob_rst;

   assign in_range = (acc_addr != '0) && (acc_addr <= LAST_A);
   assign glob_rst = wr_stb && acc_addr == SWRST_A && !wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= cfg_default(i);
      end else if (glob_rst) begin
         for (int i = 0; i < NREG; i++) regs[i] <= cfg_default(i);
      end else if (wr_stb && in_range) begin
         if (acc_addr == PWR_A)
            regs[acc_addr] <= wr_data | 8'h80;
         else
            regs[acc_addr] <= wr_data;
      end
   end

   always_comb begin
      if (acc_addr == '0)
         rd_data = ID_VALUE;
      else if (in_range)
         rd_data = regs[acc_addr];
      else
         rd_data = '0;
   end

   assign entry_q = regs[A_ENTRY];
   assign pwr_q   = regs[A_PWR];
   assign pol_q   = regs[A_POL];

   // R8
   greset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      glob_rst |=> (regs[1] == 8'h0F && regs[A_SWRST] == 8'h01));
   // R9
   pwr_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_q[7]);
   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(entry_q) && $stable(pol_q) && $stable(pwr_q)));

endmodule

// File: rtl/pcfg_decode.sv
module pcfg_decode (
   input  logic [7:0] entry_q,
   input  logic [6:0] pwr_q,
   input  logic [6:0] pol_q,
   output logic       cfg_hdir,
   output logic       cfg_vdir,
   output logic [1:0] cfg_video_std,
   output logic [3:0] cfg_in_fmt,
   output logic       cfg_pwr_normal,
   output logic [4:0] cfg_rail_en,
   output logic       cfg_pwr_auto,
   output logic       cfg_clk_rise,
   output logic       cfg_hs_high,
   output logic       cfg_vs_high,
   output logic       cfg_de_high,
   output logic       cfg_swap_chroma,
   output logic       cfg_formula_b,
   output logic       cfg_data_rev
);

   assign cfg_hdir        = entry_q[0];
   assign cfg_vdir        = entry_q[1];
   assign cfg_video_std   = entry_q[3:2];
   assign cfg_in_fmt      = entry_q[7:4];
   assign cfg_pwr_normal  = pwr_q[0];
   assign cfg_rail_en     = pwr_q[5:1];
   assign cfg_pwr_auto    = pwr_q[6];
   assign cfg_clk_rise    = pol_q[0];
   assign cfg_hs_high     = pol_q[1];
   assign cfg_vs_high     = pol_q[2];
   assign cfg_de_high     = pol_q[3];
   assign cfg_swap_chroma = pol_q[4];
   assign cfg_formula_b   = pol_q[5];
   assign cfg_data_rev    = pol_q[6];

endmodule

// File: rtl/panel_cfg_spi.sv
module panel_cfg_spi
   import panel_cfg_pkg::*;
#(
   parameter int         ADDR_W      = 7,
   parameter int         LAST_ADDR   = 'h44,
   parameter logic [7:0] ID_VALUE    = 8'h96,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sck,
   input  logic       spi_cs_n,
   input  logic       spi_mosi,
   output logic       spi_miso,
   output logic       spi_miso_oe,
   output logic       cfg_hdir,
   output logic       cfg_vdir,
   output logic [1:0] cfg_video_std,
   output logic [3:0] cfg_in_fmt,
   output logic       cfg_pwr_normal,
   output logic [4:0] cfg_rail_en,
   output logic       cfg_pwr_auto,
   output logic       cfg_clk_rise,
   output logic       cfg_hs_high,
   output logic       cfg_vs_high,
   output logic       cfg_de_high,
   output logic       cfg_swap_chroma,
   output logic       cfg_formula_b,
   output logic       cfg_data_rev
);

   generate
      if (ADDR_W + 1 != CFG_DW) begin : g_bad_hdr
         $error("header must be one data byte wide");
      end
      if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_last
         $error("LAST_ADDR does not fit the address field");
      end
      if (LAST_ADDR < A_POL) begin : g_bad_span
         $error("LAST_ADDR must cover the decoded registers");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] acc_addr;
   logic              wr_stb;
   logic [CFG_DW-1:0] wr_data, rd_data;
   logic [CFG_DW-1:0] entry_q, pwr_q, pol_q;

   pcfg_spi_front #(
      .ADDR_W(ADDR_W), .DATA_W(CFG_DW), .SYNC_STAGES(SYNC_STAGES)
   ) u_front (
      .clk(clk), .rst_n(rst_n),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .acc_addr(acc_addr), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_data(rd_data)
   );

   pcfg_regbank #(
      .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR), .ID_VALUE(ID_VALUE)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .acc_addr(acc_addr), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_data(rd_data),
      .entry_q(entry_q), .pwr_q(pwr_q), .pol_q(pol_q)
   );

   pcfg_decode u_dec (
      .entry_q(entry_q), .pwr_q(pwr_q[6:0]), .pol_q(pol_q[6:0]),
      .cfg_hdir(cfg_hdir), .cfg_vdir(cfg_vdir),
      .cfg_video_std(cfg_video_std), .cfg_in_fmt(cfg_in_fmt),
      .cfg_pwr_normal(cfg_pwr_normal), .cfg_rail_en(cfg_rail_en),
      .cfg_pwr_auto(cfg_pwr_auto),
      .cfg_clk_rise(cfg_clk_rise), .cfg_hs_high(cfg_hs_high),
      .cfg_vs_high(cfg_vs_high), .cfg_de_high(cfg_de_high),
      .cfg_swap_chroma(cfg_swap_chroma), .cfg_formula_b(cfg_formula_b),
      .cfg_data_rev(cfg_data_rev)
   );

   // R10
   dec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_in_fmt == entry_q[7:4] && cfg_rail_en == pwr_q[5:1]));

endmodule

// File: tb/panel_cfg_spi_tb.sv
module panel_cfg_spi_tb;

   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic spi_miso, spi_miso_oe;
   logic cfg_hdir, cfg_vdir, cfg_pwr_normal, cfg_pwr_auto;
   logic [1:0] cfg_video_std;
   logic [3:0] cfg_in_fmt;
   logic [4:0] cfg_rail_en;
   logic cfg_clk_rise, cfg_hs_high, cfg_vs_high, cfg_de_high;
   logic cfg_swap_chroma, cfg_formula_b, cfg_data_rev;

   always #2.5 clk = ~clk;

   panel_cfg_spi u_dut (
      .clk(clk), .rst_n(rst_n),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .cfg_hdir(cfg_hdir), .cfg_vdir(cfg_vdir),
      .cfg_video_std(cfg_video_std), .cfg_in_fmt(cfg_in_fmt),
      .cfg_pwr_normal(cfg_pwr_normal), .cfg_rail_en(cfg_rail_en),
      .cfg_pwr_auto(cfg_pwr_auto),
      .cfg_clk_rise(cfg_clk_rise), .cfg_hs_high(cfg_hs_high),
      .cfg_vs_high(cfg_vs_high), .cfg_de_high(cfg_de_high),
      .cfg_swap_chroma(cfg_swap_chroma), .cfg_formula_b(cfg_formula_b),
      .cfg_data_rev(cfg_data_rev)
   );

   int total = 0;
   int bad = 0;
   int mdl [128];
   bit idle = 1'b0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int dflt(input int a);
      case (a)
         1: return 'h0F;
         2: return 'h2E;
         3: return 'h12;
         4: return 'h01;
         6: return 'h03;
         7: return 'h80;
         10: return 'h09;
         default: return 0;
      endcase
   endfunction

   task automatic mdl_reset();
      for (int i = 0; i < 128; i++) mdl[i] = dflt(i);
   endtask

   function automatic int mdl_read(input int a);
      if (a == 0) return 'h96;
      if (a > 'h44) return 0;
      return mdl[a];
   endfunction

   task automatic mdl_write(input int a, input int d);
      if (a == 0 || a > 'h44) return;
      if (a == 4 && (d & 1) == 0) begin
         mdl_reset();
         return;
      end
      mdl[a] = (a == 7) ? (d | 'h80) : d;
   endtask

   // every clock while idle: outputs against the model (R10, R3)
   always @(negedge clk) begin
      if (idle && rst_n && !done) begin
         int e, p, q;
         int got_e, got_p, got_q;
         e = mdl[6]; p = mdl[7]; q = mdl[10];
         got_e = {cfg_in_fmt, cfg_video_std, cfg_vdir, cfg_hdir};
         got_p = {cfg_pwr_auto, cfg_rail_en, cfg_pwr_normal};
         got_q = {cfg_data_rev, cfg_formula_b, cfg_swap_chroma, cfg_de_high,
                  cfg_vs_high, cfg_hs_high, cfg_clk_rise};
         check(got_e == e, "R10 entry", got_e, e);
         check(got_p == (p & 'h7F), "R10 power", got_p, p & 'h7F);
         check(got_q == (q & 'h7F), "R10 polarity", got_q, q & 'h7F);
         check(!spi_miso_oe && !spi_miso, "R3 idle", {spi_miso_oe, spi_miso}, 0);
      end
   end

   task automatic xfer(input int b0, input int b1, input int nclk, input string tag);
      logic [15:0] fr;
      int exp_rd;
      bit is_rd;
      int a;
      fr = {b0[7:0], b1[7:0]};
      is_rd = b0[7];
      a = b0 & 'h7F;
      exp_rd = mdl_read(a);
      idle = 1'b0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int k = 0; k < nclk; k++) begin
         spi_mosi = fr[15-k];
         repeat (HALF) @(negedge clk);
         if (k >= 8 && is_rd) begin
            check(spi_miso_oe == 1'b1, "R3 oe in data byte", spi_miso_oe, 1);
            check(spi_miso == exp_rd[15-k], tag, spi_miso, exp_rd[15-k]);
         end else begin
            check(!spi_miso_oe && !spi_miso, "R3 header/write", {spi_miso_oe, spi_miso}, 0);
         end
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      if (nclk == 16 && !is_rd) mdl_write(a, b1);
      repeat (8) @(negedge clk);
      idle = 1'b1;
   endtask

   task automatic wr(input int a, input int d);
      xfer(a & 'h7F, d, 16, "R1 write");
   endtask

   task automatic rd(input int a, input string tag);
      xfer('h80 | a, 'hA5, 16, tag);
   endtask

   initial begin
      int seed;
      mdl_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      idle = 1'b1;
      repeat (4) @(negedge clk);

      // R7 defaults and R2 read path
      rd('h01, "R7 default 01");
      rd('h02, "R7 default 02");
      rd('h03, "R7 default 03");
      rd('h04, "R7 default 04");
      rd('h05, "R7 default 05");
      rd('h06, "R7 default 06");
      rd('h07, "R7 default 07");
      rd('h0A, "R7 default 0A");
      rd('h44, "R7 default 44");

      // R5 identification
      rd('h00, "R5 id read");
      wr('h00, 'h55);
      rd('h00, "R5 id after write");

      // R1/R2 write and read back, R10 decode
      wr('h01, 'hA5);
      rd('h01, "R2 readback 01");
      wr('h06, 'hB6);
      wr('h0A, 'h76);
      wr('h07, 'h15);
      rd('h07, "R9 power msb");
      rd('h06, "R2 readback 06");
      rd('h0A, "R2 readback 0A");
      wr('h07, 'hFF);
      rd('h07, "R9 power all ones");

      // R6 out of range
      wr('h44, 'h3C);
      rd('h44, "R6 last valid");
      wr('h45, 'h77);
      rd('h45, "R6 above range");
      wr('h7F, 'h11);
      rd('h7F, "R6 top address");

      // R4 truncated frames
      xfer('h01, 'h33, 10, "R4 short 10");
      rd('h01, "R4 after 10 clocks");
      xfer('h06, 'h00, 15, "R4 short 15");
      rd('h06, "R4 after 15 clocks");
      xfer('h02, 'h44, 3, "R4 short 3");
      rd('h02, "R4 after 3 clocks");

      // R8 global reset register
      wr('h04, 'h03);
      rd('h04, "R8 stored bit0 set");
      rd('h01, "R8 no reset on bit0 set");
      wr('h04, 'hFE);
      rd('h04, "R8 after global reset 04");
      rd('h01, "R8 after global reset 01");
      rd('h06, "R8 after global reset 06");
      rd('h44, "R8 after global reset 44");
      rd('h07, "R8 after global reset 07");

      // R11 asynchronous reset
      wr('h03, 'h5A);
      wr('h0A, 'h00);
      idle = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      mdl_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      idle = 1'b1;
      rd('h03, "R11 reset 03");
      rd('h0A, "R11 reset 0A");

      // mixed traffic
      seed = 32'h1D5A;
      for (int n = 0; n < 30; n++) begin
         int a, d;
         seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
         a = (seed >> 8) % 'h50;
         d = (seed >> 3) & 'hFF;
         if (a == 4 && (n % 3) != 0) d = d | 1;
         wr(a, d);
         rd(a, "R1 mixed readback");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule